// File: doc/BRIEF.md
# Card Status Change Event Controller

This block collects status-change events for one card function and drives a single active-high status-change output. Six live card lines are watched: write protect, ready, two battery-voltage-detect lines, general wake and the card interrupt line. Each passes through a synchronizer. A level change on any of the first five, rising or falling, latches a sticky event bit. Software reads the events through a small 32-bit register port. It clears an event by writing a one to its bit, selects which events may raise the output with a mask, and can inject events directly through a force register for test.

Every register uses the same bit layout: write protect bit 0, ready bit 1, second battery-detect line bit 2, first battery-detect line bit 3, general wake bit 4, interrupt bit 15. Mask bit 14 is a global wake enable. The output rises only when that bit is set and a pending event is also unmasked. The interrupt line is visible as a level, but it never latches an event by itself. Event bit 15 can only be set through the force register.

Top module: `csc_event_ctrl`

## Requirements
- R1: Register word offsets are 0x0 event, 0x4 mask, 0x8 present state and 0xC force. Reading the force offset returns zero. Address bits [1:0] must be zero for an access to hit.
- R2: Event bits are write-one-to-clear. A zero written to an event bit leaves it unchanged, so a write of all zeros has no effect.
- R3: The present-state register returns the synchronized levels of the six card lines at the shared bit positions, two clocks after an input changes. Writes to it are ignored and change no register.
- R4: Writing a one to a force bit sets the matching event bit. The forced bits are ORed with the pending events, so forcing 0x0011 and then 0x8007 reads back as 0x8017.
- R5: While mask bit 14 is zero, the status output stays low even when unmasked events are pending.
- R6: The status output is registered. One clock after mask bit 14 is set and (event & mask) is nonzero in bits {15,4:0}, it is high. Otherwise it is low.
- R7: A rising or falling change on write protect, ready, either battery-detect line or general wake sets its event bit on the third clock edge after the change.
- R8: A change on the interrupt line updates state bit 15 but never sets event bit 15.
- R9: Bits 5 to 13 and 16 to 31 read as zero in every register and ignore writes. Mask bits 0 to 4, 14 and 15 are writable and read back.
- R10: When an input change or a force sets an event bit in the same clock as a write that clears it, the bit ends set.
- R11: Synchronous active-high reset clears the event and mask registers and drives the status output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| cardWp | input | 1 | Write-protect line |
| cardReady | input | 1 | Ready line |
| cardBvd2 | input | 1 | Second battery-voltage-detect line |
| cardBvd1 | input | 1 | First battery-voltage-detect line |
| cardWake | input | 1 | General wake line |
| cardIntr | input | 1 | Card interrupt line |
| statusChg | output | 1 | Status-change output, active high |

## Verification
A set and a clear can meet on the same event bit in one clock. This happens when a software clear lands on the edge where a synchronized input change sets the bit. The bench provokes it by issuing the clear write two clocks after it moves the second battery-detect line, so the write lands exactly on the setting edge. It then expects the bit to remain set. A behavioural reference model, updated every clock, also judges each cycle's read data and status output. This covers mask and wake-enable changes that coincide with new events.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int REG_W   = 32;
  localparam int SRC_W   = 6;
  localparam int WP_BIT   = 0;
  localparam int RDY_BIT  = 1;
  localparam int BVD2_BIT = 2;
  localparam int BVD1_BIT = 3;
  localparam int WAKE_BIT = 4;
  localparam int WKEN_BIT = 14;
  localparam int INTR_BIT = 15;

  // Source vector index order: wp, ready, bvd2, bvd1, wake, intr
  localparam logic [REG_W-1:0] EV_MASK   = (REG_W'(1) << INTR_BIT) | REG_W'(32'h1F);
  localparam logic [REG_W-1:0] CHG_MASK  = REG_W'(32'h1F);
  localparam logic [REG_W-1:0] MASK_MASK = EV_MASK | (REG_W'(1) << WKEN_BIT);

  typedef enum logic [1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_STATE = 2'd2,
    SEL_FORCE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    evClr;
    logic    maskWr;
    logic    forceWr;
    logic    rdHit;
    regSel_e rdSel;
  } cscStrobe_t;

  function automatic logic [REG_W-1:0] srcToReg(input logic [SRC_W-1:0] s);
    logic [REG_W-1:0] r;
    r = '0;
    r[WP_BIT]   = s[0];
    r[RDY_BIT]  = s[1];
    r[BVD2_BIT] = s[2];
    r[BVD1_BIT] = s[3];
    r[WAKE_BIT] = s[4];
    r[INTR_BIT] = s[5];
    return r;
  endfunction
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output cscStrobe_t        strb
);
  localparam int WORD_LSB = 2;
  localparam int HI_LSB   = WORD_LSB + 2;
  localparam int HI_W     = ADDR_W - HI_LSB;

  logic    hiZero;
  logic    aligned;
  logic    hit;
  regSel_e sel;

  generate
    if (HI_W > 0) begin : g_hi
      assign hiZero = ~|regAddr[ADDR_W-1:HI_LSB];
    end else begin : g_nohi
      assign hiZero = 1'b1;
    end
  endgenerate

  assign aligned = ~|regAddr[WORD_LSB-1:0];
  assign hit     = hiZero & aligned;
  assign sel     = regSel_e'(regAddr[WORD_LSB +: 2]);

  always_comb begin
    strb         = '0;
    strb.rdHit   = hit;
    strb.rdSel   = sel;
    strb.evClr   = regWe & hit & (sel == SEL_EVENT);
    strb.maskWr  = regWe & hit & (sel == SEL_MASK);
    strb.forceWr = regWe & hit & (sel == SEL_FORCE);
  end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int NUM_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  cscStrobe_t       strb,
  input  logic [REG_W-1:0] wdata,
  input  logic [SRC_W-1:0] srcIn,
  output logic [REG_W-1:0] rdata,
  output logic             statusChg
);
  logic [NUM_SYNC:0][SRC_W-1:0] syncQ;
  logic [SRC_W-1:0] liveLvl;
  logic [SRC_W-1:0] prevLvl;
  logic [REG_W-1:0] eventQ;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] chgBits;
  logic [REG_W-1:0] forceBits;
  logic [REG_W-1:0] clrBits;
  logic [REG_W-1:0] setBits;
  logic             pendHit;

  always_ff @(posedge clk) begin
    if (rst) syncQ[0] <= '0;
    else     syncQ[0] <= srcIn;
  end

  generate
    for (genvar i = 1; i <= NUM_SYNC; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncQ[i] <= '0;
        else     syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  assign liveLvl   = syncQ[NUM_SYNC-1];
  assign prevLvl   = syncQ[NUM_SYNC];
  assign chgBits   = srcToReg(liveLvl ^ prevLvl) & CHG_MASK;
  assign forceBits = strb.forceWr ? (wdata & EV_MASK) : '0;
  assign clrBits   = strb.evClr ? (wdata & EV_MASK) : '0;
  assign setBits   = chgBits | forceBits;
  assign pendHit   = |(eventQ & maskQ & EV_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      eventQ    <= '0;
      maskQ     <= '0;
      statusChg <= 1'b0;
    end else begin
      eventQ    <= (eventQ & ~clrBits) | setBits;
      if (strb.maskWr) maskQ <= wdata & MASK_MASK;
      statusChg <= maskQ[WKEN_BIT] & pendHit;
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.rdHit) begin
      unique case (strb.rdSel)
        SEL_EVENT: rdata = eventQ;
        SEL_MASK:  rdata = maskQ;
        SEL_STATE: rdata = srcToReg(liveLvl);
        SEL_FORCE: rdata = '0;
        default:   rdata = '0;
      endcase
    end
  end

  // R5: output only high if wake enable was set on the previous edge
  p_wake_gate_r5: assert property (@(posedge clk) disable iff (rst)
    statusChg |-> $past(maskQ[WKEN_BIT]));

  // R2: with no clear request bits and no set source, events hold
  p_zero_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!strb.forceWr && (chgBits == '0) && (!strb.evClr || ((wdata & EV_MASK) == '0)))
    |=> (eventQ == $past(eventQ)));

  // R4: forced bits are present in the event register next cycle
  p_force_sets_r4: assert property (@(posedge clk) disable iff (rst)
    strb.forceWr |=> ((eventQ & $past(wdata & EV_MASK)) == $past(wdata & EV_MASK)));

  // R10: any set source wins over a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (setBits != '0) |=> ((eventQ & $past(setBits)) == $past(setBits)));

  // R8: interrupt event bit only rises through a force write
  p_intr_force_only_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(eventQ[INTR_BIT]) |-> $past(strb.forceWr));
endmodule

// File: rtl/csc_event_ctrl.sv
module csc_event_ctrl
  import csc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              cardWp,
  input  logic              cardReady,
  input  logic              cardBvd2,
  input  logic              cardBvd1,
  input  logic              cardWake,
  input  logic              cardIntr,
  output logic              statusChg
);
  cscStrobe_t       strb;
  logic [SRC_W-1:0] srcIn;

  assign srcIn = {cardIntr, cardWake, cardBvd1, cardBvd2, cardReady, cardWp};

  csc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  csc_datapath #(.NUM_SYNC(NUM_SYNC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wdata     (regWdata),
    .srcIn     (srcIn),
    .rdata     (regRdata),
    .statusChg (statusChg)
  );

  // R9: reserved bit positions never read back as one
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ((regRdata & ~MASK_MASK) == '0));
endmodule

// File: tb/tb_csc_event_ctrl.sv
module tb_csc_event_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic cardWp = 0, cardReady = 0, cardBvd2 = 0, cardBvd1 = 0, cardWake = 0, cardIntr = 0;
  logic statusChg;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csc_event_ctrl dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .cardWp(cardWp), .cardReady(cardReady), .cardBvd2(cardBvd2),
    .cardBvd1(cardBvd1), .cardWake(cardWake), .cardIntr(cardIntr),
    .statusChg(statusChg)
  );

  // Behavioural reference model
  logic [31:0] mS1 = 0, mS2 = 0, mS3 = 0, mEv = 0, mMask = 0;
  logic mStat = 0;

  function automatic logic [31:0] liveVec();
    return {16'h0, cardIntr, 10'h0, cardWake, cardBvd1, cardBvd2, cardReady, cardWp};
  endfunction

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0: return mEv;
      2'd1: return mMask;
      2'd2: return mS2;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] setB, clrB;
    if (rst) begin
      mS1 = 0; mS2 = 0; mS3 = 0; mEv = 0; mMask = 0; mStat = 0;
    end else begin
      setB = (mS2 ^ mS3) & 32'h1F;
      clrB = 0;
      if (regWe && regAddr == 4'hC) setB = setB | (regWdata & 32'h801F);
      if (regWe && regAddr == 4'h0) clrB = regWdata & 32'h801F;
      mStat = mMask[14] && ((mEv & mMask & 32'h801F) != 0);
      mEv = (mEv & ~clrB) | setB;
      if (regWe && regAddr == 4'h4) mMask = regWdata & 32'hC01F;
      mS3 = mS2; mS2 = mS1; mS1 = liveVec();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      check("R6 statusChg vs model", {31'h0, statusChg}, {31'h0, mStat});
      check("R1 regRdata vs model", regRdata, modelRead(regAddr));
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regWe = 1'b0;
    @(posedge clk); #2; d = regRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    // R11: reset state
    check("R11 statusChg in reset", {31'h0, statusChg}, 32'h0);
    @(negedge clk); rst = 1'b0;
    regRead(4'h0, rd); check("R11 event after reset", rd, 32'h0);
    regRead(4'h4, rd); check("R11 mask after reset", rd, 32'h0);

    // R7 / R3: rising change on ready
    @(negedge clk); cardReady = 1;
    idle(4);
    regRead(4'h0, rd); check("R7 ready rise event", rd, 32'h2);
    regRead(4'h8, rd); check("R3 state ready level", rd, 32'h2);
    regWrite(4'h0, 32'h2);
    regRead(4'h0, rd); check("R2 clear ready event", rd, 32'h0);
    // R7: falling change
    @(negedge clk); cardReady = 0;
    idle(4);
    regRead(4'h0, rd); check("R7 ready fall event", rd, 32'h2);
    @(negedge clk); cardWp = 1; cardBvd1 = 1; cardWake = 1;
    idle(4);
    regRead(4'h0, rd); check("R7 wp/bvd1/wake events", rd, 32'h1B);
    regWrite(4'h0, 32'hFFFF_FFFF);
    @(negedge clk); cardWp = 0; cardBvd1 = 0; cardWake = 0;
    idle(4);
    regWrite(4'h0, 32'hFFFF_FFFF);

    // R8: interrupt line
    @(negedge clk); cardIntr = 1;
    idle(4);
    regRead(4'h8, rd); check("R8 state intr level", rd, 32'h8000);
    regRead(4'h0, rd); check("R8 no intr event", rd, 32'h0);

    // R2: zero write has no effect
    regWrite(4'hC, 32'h1F);
    regWrite(4'h0, 32'h0);
    regRead(4'h0, rd); check("R2 zero write no effect", rd, 32'h1F);
    regWrite(4'h0, 32'h3);
    regRead(4'h0, rd); check("R2 partial clear", rd, 32'h1C);

    // R3: state write ignored
    regWrite(4'h8, 32'h1234_5678);
    regRead(4'h8, rd); check("R3 state write ignored", rd, 32'h8000);
    regRead(4'h0, rd); check("R3 event untouched by state write", rd, 32'h1C);
    regRead(4'h4, rd); check("R3 mask untouched by state write", rd, 32'h0);

    // R4: force OR
    regWrite(4'h0, 32'hFFFF_FFFF);
    regWrite(4'hC, 32'h0011);
    regWrite(4'hC, 32'h8007);
    regRead(4'h0, rd); check("R4 forced OR", rd, 32'h8017);
    regRead(4'hC, rd); check("R1 force reads zero", rd, 32'h0);
    regRead(4'h1, rd); check("R1 unaligned reads zero", rd, 32'h0);

    // R5 / R6: wake enable gating
    regWrite(4'h4, 32'h801F);
    idle(2);
    check("R5 no wake enable output low", {31'h0, statusChg}, 32'h0);
    regWrite(4'h4, 32'hC01F);
    idle(1);
    check("R6 output high", {31'h0, statusChg}, 32'h1);
    regWrite(4'h0, 32'hFFFF_FFFF);
    idle(1);
    check("R6 output low after clear", {31'h0, statusChg}, 32'h0);
    regWrite(4'hC, 32'h10);
    regWrite(4'h4, 32'hC001);
    idle(1);
    check("R6 masked event output low", {31'h0, statusChg}, 32'h0);

    // R9: reserved bits
    regWrite(4'h4, 32'hFFFF_FFFF);
    regRead(4'h4, rd); check("R9 mask writable bits", rd, 32'hC01F);
    regWrite(4'hC, 32'hFFFF_FFFF);
    regRead(4'h0, rd); check("R9 event reserved zero", rd, 32'h801F);
    regWrite(4'h0, 32'hFFFF_FFFF);

    // R10: set and clear in same cycle
    @(negedge clk); cardBvd2 = 1;
    @(negedge clk);
    @(negedge clk); regAddr = 4'h0; regWdata = 32'h4; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
    regRead(4'h0, rd); check("R10 set wins over clear", rd, 32'h4);

    // R11: reset mid-run
    regWrite(4'h4, 32'hC01F);
    idle(2);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R11 output low in reset", {31'h0, statusChg}, 32'h0);
    @(negedge clk); rst = 1'b0; cardBvd2 = 0; cardIntr = 0;
    regRead(4'h0, rd); check("R11 event cleared by reset", rd, 32'h0);
    regRead(4'h4, rd); check("R11 mask cleared by reset", rd, 32'h0);
    idle(6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule